// File: doc/BRIEF.md
# Two-Entry Byte Buffers with Service Flags

This block holds the bytes that pass between a host register interface and a serial shift engine for a two-wire bus controller. It has two independent byte queues: one carries bytes written by the host toward the engine, and the other carries bytes received by the engine back toward the host. Each queue holds at most two bytes. The bus protocol itself lives elsewhere.

The host sees a four-bit level field that reports each queue as empty, holding one byte, or full. A four-bit control register holds a flush bit and a threshold-select bit for each queue. An eight-bit sticky event register records the transmit-service and receive-service conditions, a rejected host write, and a host read of an empty queue. Writing a one to a bit of the event register clears that bit. A mask register decides which events drive the single interrupt line. The mask does not change the event bits themselves.

The host normally polls or takes an interrupt, writes the next byte when transmit service is pending, and reads a byte when receive service is pending. It can also set a threshold bit so that it is interrupted only once per pair of bytes.

Top module: `byte_xfer_buffers`

## Requirements
- R1: Each queue holds at most two bytes and returns them in the order they were written.
- R2: Level field `lvl_stat` is transmit in bits 1:0 and receive in bits 3:2. The encoding is 00 for empty, 01 for one byte, and 11 for full. The value 10 never appears.
- R3: A host write to a full transmit queue drops the byte and sets event bit 1 (write error). The full test uses the occupancy before the clock edge, even when the engine pops in the same cycle.
- R4: A host read of an empty receive queue returns 0x00 and sets event bit 0 (read error).
- R5: Control bit 0 (transmit) and bit 1 (receive) are level flush bits. While a flush bit is high, its queue reads as empty and any push into it is ignored without an error. Bytes flushed out are never delivered.
- R6: Event bit 6 (transmit service) is set whenever the transmit queue has a free slot if control bit 2 is 0, or only when that queue is empty if control bit 2 is 1.
- R7: Event bit 7 (receive service) is set whenever the receive queue holds a byte if control bit 3 is 0, or only when that queue is full if control bit 3 is 1.
- R8: Writing ones to the event register clears those bits. A service bit whose condition still holds is set again on the next cycle. An error raised in the same cycle as its clear stays set.
- R9: `irq` is high exactly when some event bit and its mask bit are both set. The mask never alters the event register contents.
- R10: An engine pop from an empty transmit queue, or an engine push into a full receive queue, changes nothing.
- R11: While reset is high, both queues are empty, the event, mask and control registers are zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Load the control register |
| ctl_wdata | input | 4 | Control: bit0 tx flush, bit1 rx flush, bit2 tx threshold, bit3 rx threshold |
| mask_wr | input | 1 | Load the interrupt mask |
| mask_wdata | input | 8 | Mask value |
| evt_clr_wr | input | 1 | Write-one-to-clear strobe for the event register |
| evt_clr_data | input | 8 | Bits to clear |
| host_tx_wr | input | 1 | Host pushes a byte into the transmit queue |
| host_tx_data | input | 8 | Byte to push |
| host_rx_rd | input | 1 | Host pops a byte from the receive queue |
| host_rx_data | output | 8 | Registered byte returned by the last host read |
| eng_tx_valid | output | 1 | Transmit queue holds a byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_pop | input | 1 | Engine consumes the oldest transmit byte |
| eng_rx_ready | output | 1 | Receive queue has a free slot |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| lvl_stat | output | 4 | Level field per queue (R2) |
| evt_stat | output | 8 | Sticky event register |
| irq | output | 1 | Masked interrupt |

## Verification
The bench targets the threshold switch. A design that ignored the threshold bit would keep transmit service set after one byte was queued, or raise receive service on the first byte instead of the second. It writes to a full queue in the same cycle as an engine pop. A design that tested occupancy after the pop would accept the byte instead of flagging it. It clears service bits while their conditions hold, and clears an error in the same cycle a new one arrives. Clear logic with the wrong priority would leave the register empty. It pushes bytes during a flush and then pops after the flush. Stale bytes or a spurious error would appear if flush only reset pointers once. It also moves the mask while events are pending, to catch a design that gates the status bits instead of only the interrupt line.

// File: rtl/xb_pkg.sv
package xb_pkg;
  // control register fields
  localparam int CTL_W   = 4;
  localparam int FL_TX   = 0;
  localparam int FL_RX   = 1;
  localparam int LEN_TX  = 2;
  localparam int LEN_RX  = 3;

  // event register fields
  localparam int EVT_W   = 8;
  localparam int ERR_RD  = 0;
  localparam int ERR_WR  = 1;
  localparam int SVC_TX  = 6;
  localparam int SVC_RX  = 7;

  typedef enum logic [1:0] {
    LVL_EMPTY = 2'b00,
    LVL_PART  = 2'b01,
    LVL_FULL  = 2'b11
  } lvl_e;

  function automatic lvl_e lvl_code(input logic is_empty, input logic is_full);
    if (is_empty)     return LVL_EMPTY;
    else if (is_full) return LVL_FULL;
    else              return LVL_PART;
  endfunction
endpackage

// File: rtl/xb_fifo.sv
module xb_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !flush && !full;
  assign do_pop  = pop  && !flush && !empty;
  assign head    = mem[rptr];

  // storage: no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= ptr_next(wptr);
      if (do_pop)  rptr <= ptr_next(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  a_r5_flush_empty: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);

  a_r3_full_hold: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !flush && full) |=> full);

  a_r10_pop_empty: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && empty) |=> empty);
endmodule

// File: rtl/xb_evt_reg.sv
module xb_evt_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] flags
);
  logic [N-1:0] clr_eff;
  assign clr_eff = clr_wr ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr_eff) | set;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> flags[i]);
    a_r8_w1c: assert property (@(posedge clk) disable iff (rst)
      (clr_eff[i] && !set[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/byte_xfer_buffers.sv
module byte_xfer_buffers
  import xb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              mask_wr,
  input  logic [EVT_W-1:0]  mask_wdata,
  input  logic              evt_clr_wr,
  input  logic [EVT_W-1:0]  evt_clr_data,
  input  logic              host_tx_wr,
  input  logic [DATA_W-1:0] host_tx_data,
  input  logic              host_rx_rd,
  output logic [DATA_W-1:0] host_rx_data,
  output logic              eng_tx_valid,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_tx_pop,
  output logic              eng_rx_ready,
  input  logic              eng_rx_push,
  input  logic [DATA_W-1:0] eng_rx_data,
  output logic [3:0]        lvl_stat,
  output logic [EVT_W-1:0]  evt_stat,
  output logic              irq
);
  logic [CTL_W-1:0]  ctl_q;
  logic [EVT_W-1:0]  mask_q;
  logic [EVT_W-1:0]  evt_set;
  logic [DATA_W-1:0] rx_head;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic tx_svc, rx_svc, wr_err, rd_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      mask_q <= '0;
    end else begin
      if (ctl_wr)  ctl_q  <= ctl_wdata;
      if (mask_wr) mask_q <= mask_wdata;
    end
  end

  xb_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst(rst), .flush(ctl_q[FL_TX]),
    .push(host_tx_wr), .push_data(host_tx_data),
    .pop(eng_tx_pop), .head(eng_tx_data),
    .empty(tx_empty), .full(tx_full)
  );

  xb_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst(rst), .flush(ctl_q[FL_RX]),
    .push(eng_rx_push), .push_data(eng_rx_data),
    .pop(host_rx_rd), .head(rx_head),
    .empty(rx_empty), .full(rx_full)
  );

  assign eng_tx_valid = !tx_empty;
  assign eng_rx_ready = !rx_full;

  // registered host read port
  always_ff @(posedge clk) begin
    if (rst) host_rx_data <= '0;
    else if (host_rx_rd)
      host_rx_data <= (rx_empty || ctl_q[FL_RX]) ? '0 : rx_head;
  end

  assign lvl_stat = {lvl_code(rx_empty, rx_full), lvl_code(tx_empty, tx_full)};

  assign tx_svc = ctl_q[LEN_TX] ? tx_empty : !tx_full;
  assign rx_svc = ctl_q[LEN_RX] ? rx_full  : !rx_empty;
  assign wr_err = host_tx_wr && tx_full && !ctl_q[FL_TX];
  assign rd_err = host_rx_rd && (rx_empty || ctl_q[FL_RX]);

  always_comb begin
    evt_set         = '0;
    evt_set[ERR_RD] = rd_err;
    evt_set[ERR_WR] = wr_err;
    evt_set[SVC_TX] = tx_svc;
    evt_set[SVC_RX] = rx_svc;
  end

  xb_evt_reg #(.N(EVT_W)) u_evt (
    .clk(clk), .rst(rst), .set(evt_set),
    .clr_wr(evt_clr_wr), .clr_bits(evt_clr_data), .flags(evt_stat)
  );

  assign irq = |(evt_stat & mask_q);

  a_r2_no_code_10: assert property (@(posedge clk) disable iff (rst)
    (lvl_stat[1:0] != 2'b10) && (lvl_stat[3:2] != 2'b10));

  a_r3_wr_err: assert property (@(posedge clk) disable iff (rst)
    (host_tx_wr && !eng_tx_pop && lvl_stat[1:0] == 2'b11 && !ctl_q[FL_TX])
      |=> evt_stat[ERR_WR]);

  a_r4_rd_zero: assert property (@(posedge clk) disable iff (rst)
    (host_rx_rd && lvl_stat[3:2] == 2'b00) |=> (host_rx_data == '0) && evt_stat[ERR_RD]);

  a_r6_tx_svc: assert property (@(posedge clk) disable iff (rst)
    tx_svc |=> evt_stat[SVC_TX]);

  a_r7_rx_svc: assert property (@(posedge clk) disable iff (rst)
    rx_svc |=> evt_stat[SVC_RX]);

  a_r9_irq_mask: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((evt_stat & mask_q) != '0));
endmodule

// File: tb/byte_xfer_buffers_bench.sv
module byte_xfer_buffers_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 0, mask_wr = 0, evt_clr_wr = 0;
  logic [3:0] ctl_wdata = '0;
  logic [7:0] mask_wdata = '0, evt_clr_data = '0;
  logic       host_tx_wr = 0, host_rx_rd = 0, eng_tx_pop = 0, eng_rx_push = 0;
  logic [7:0] host_tx_data = '0, eng_rx_data = '0;
  logic [7:0] host_rx_data, eng_tx_data, evt_stat;
  logic       eng_tx_valid, eng_rx_ready, irq;
  logic [3:0] lvl_stat;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  byte_xfer_buffers u_byte_xfer_buffers (
    .clk(clk), .rst(rst),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .evt_clr_wr(evt_clr_wr), .evt_clr_data(evt_clr_data),
    .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
    .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data),
    .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data), .eng_tx_pop(eng_tx_pop),
    .eng_rx_ready(eng_rx_ready), .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .lvl_stat(lvl_stat), .evt_stat(evt_stat), .irq(irq)
  );

  // op: 1 host push, 2 engine pop, 3 engine push, 4 host read, 5 control, 6 clear, 7 mask
  typedef struct packed {
    logic [2:0] op;
    logic [7:0] arg;
    logic       chk;
    logic [7:0] dat;
    logic [3:0] lvl;
    logic [7:0] evt;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VT [NV] = '{
    '{3'd6, 8'hFF, 1'b0, 8'h00, 4'h0, 8'h40},
    '{3'd5, 8'h04, 1'b0, 8'h00, 4'h0, 8'h40},
    '{3'd1, 8'hA1, 1'b0, 8'h00, 4'h1, 8'h40},
    '{3'd6, 8'h40, 1'b0, 8'h00, 4'h1, 8'h00},
    '{3'd1, 8'hB2, 1'b0, 8'h00, 4'h3, 8'h00},
    '{3'd1, 8'hC3, 1'b0, 8'h00, 4'h3, 8'h02},
    '{3'd2, 8'h00, 1'b1, 8'hA1, 4'h1, 8'h02},
    '{3'd2, 8'h00, 1'b1, 8'hB2, 4'h0, 8'h42},
    '{3'd2, 8'h00, 1'b0, 8'h00, 4'h0, 8'h42},
    '{3'd6, 8'hFF, 1'b0, 8'h00, 4'h0, 8'h40},
    '{3'd3, 8'h5A, 1'b0, 8'h00, 4'h4, 8'hC0},
    '{3'd3, 8'h6B, 1'b0, 8'h00, 4'hC, 8'hC0},
    '{3'd3, 8'h7C, 1'b0, 8'h00, 4'hC, 8'hC0},
    '{3'd4, 8'h00, 1'b1, 8'h5A, 4'h4, 8'hC0},
    '{3'd5, 8'h0C, 1'b0, 8'h00, 4'h4, 8'hC0},
    '{3'd6, 8'h80, 1'b0, 8'h00, 4'h4, 8'h40},
    '{3'd3, 8'h8D, 1'b0, 8'h00, 4'hC, 8'hC0},
    '{3'd4, 8'h00, 1'b1, 8'h6B, 4'h4, 8'hC0},
    '{3'd4, 8'h00, 1'b1, 8'h8D, 4'h0, 8'hC0},
    '{3'd4, 8'h00, 1'b1, 8'h00, 4'h0, 8'hC1},
    '{3'd1, 8'h11, 1'b0, 8'h00, 4'h1, 8'hC1},
    '{3'd1, 8'h22, 1'b0, 8'h00, 4'h3, 8'hC1},
    '{3'd5, 8'h0D, 1'b0, 8'h00, 4'h0, 8'hC1},
    '{3'd1, 8'h33, 1'b0, 8'h00, 4'h0, 8'hC1},
    '{3'd5, 8'h0C, 1'b0, 8'h00, 4'h0, 8'hC1},
    '{3'd1, 8'h44, 1'b0, 8'h00, 4'h1, 8'hC1},
    '{3'd2, 8'h00, 1'b1, 8'h44, 4'h0, 8'hC1},
    '{3'd3, 8'h99, 1'b0, 8'h00, 4'h4, 8'hC1},
    '{3'd5, 8'h0E, 1'b0, 8'h00, 4'h0, 8'hC1},
    '{3'd5, 8'h0C, 1'b0, 8'h00, 4'h0, 8'hC1},
    '{3'd6, 8'hFF, 1'b0, 8'h00, 4'h0, 8'h40}
  };

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd1: return "R3 R1";
      3'd2: return "R10 R1";
      3'd3: return "R10 R7";
      3'd4: return "R4 R1";
      3'd5: return "R5 R6";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_op(input logic [2:0] op, input logic [7:0] arg);
    case (op)
      3'd1: begin host_tx_wr = 1; host_tx_data = arg; end
      3'd2: eng_tx_pop = 1;
      3'd3: begin eng_rx_push = 1; eng_rx_data = arg; end
      3'd4: host_rx_rd = 1;
      3'd5: begin ctl_wr = 1; ctl_wdata = arg[3:0]; end
      3'd6: begin evt_clr_wr = 1; evt_clr_data = arg; end
      default: begin mask_wr = 1; mask_wdata = arg; end
    endcase
  endtask

  task automatic idle_and_settle();
    @(negedge clk);
    host_tx_wr = 0; eng_tx_pop = 0; eng_rx_push = 0; host_rx_rd = 0;
    ctl_wr = 0; evt_clr_wr = 0; mask_wr = 0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic apply(input logic [2:0] op, input logic [7:0] arg);
    @(negedge clk);
    set_op(op, arg);
    idle_and_settle();
  endtask

  initial begin : watchdog
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] pre;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    check("R11 lvl", {4'h0, lvl_stat}, 8'h00);
    check("R11 evt", evt_stat, 8'h00);
    check("R11 irq", {7'd0, irq}, 8'h00);
    rst = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R6 after reset", evt_stat, 8'h40);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pre = eng_tx_data;
      set_op(VT[i].op, VT[i].arg);
      idle_and_settle();
      if (VT[i].chk)
        check({tag_of(VT[i].op), " data"},
              (VT[i].op == 3'd2) ? pre : host_rx_data, VT[i].dat);
      check({tag_of(VT[i].op), " R2 lvl"}, {4'h0, lvl_stat}, {4'h0, VT[i].lvl});
      check({tag_of(VT[i].op), " R6 R7 evt"}, evt_stat, VT[i].evt);
    end

    // R9: mask gates only the interrupt line
    check("R9 masked off", {7'd0, irq}, 8'h00);
    apply(3'd7, 8'h40);
    check("R9 unmasked", {7'd0, irq}, 8'h01);
    apply(3'd7, 8'h80);
    check("R9 other bit", {7'd0, irq}, 8'h00);
    check("R9 status ungated", evt_stat, 8'h40);

    // R3: full test uses occupancy before a same-cycle pop
    apply(3'd5, 8'h00);
    apply(3'd1, 8'h01);
    apply(3'd1, 8'h02);
    @(negedge clk);
    host_tx_wr = 1; host_tx_data = 8'h03; eng_tx_pop = 1;
    idle_and_settle();
    check("R3 lvl after push+pop", {4'h0, lvl_stat}, 8'h01);
    check("R3 wr error", evt_stat & 8'h02, 8'h02);
    check("R1 R3 head", eng_tx_data, 8'h02);

    // R8: error raised in the same cycle as its clear stays set
    apply(3'd6, 8'hFF);
    @(negedge clk);
    host_rx_rd = 1; evt_clr_wr = 1; evt_clr_data = 8'h01;
    idle_and_settle();
    check("R8 R4 set beats clear", evt_stat & 8'h01, 8'h01);
    check("R4 zero data", host_rx_data, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule